// File: doc/BRIEF.md
# Local interrupt countdown timer

This block is a programmable down-counter that requests a local interrupt when it runs out. Software sets it up through a small register port. A divide-configuration register selects a power-of-two prescale of the input clock. An initial-count register loads and restarts the counter. A control entry holds a mask bit, a periodic/one-shot bit and an 8-bit interrupt vector. The live count can be read at any time.

Each time the counter expires, the block drives a one-cycle request pulse together with the vector from the control entry, unless the entry is masked. In one-shot mode the counter stops at zero after it fires once. In periodic mode it reloads from the initial count, so it fires every initial+1 prescaled ticks. Whatever consumes the request pulse is outside this block.

Top module: `irq_countdown_timer`

## Requirements
- R1: After a synchronous active-low reset, the control entry reads 0x00010000 (masked). The initial count, the divide register and the current count read 0. No pulse is driven.
- R2: The divide register keeps only bits 3, 1 and 0, so 0xFF reads back as 0x0B. A code c = {bit3, bit1, bit0} gives a prescale of 2^((c+1) mod 8). Code 7 divides by 1 and code 0 divides by 2.
- R3: Writing N to the initial count loads N into the current count at that edge and restarts the prescaler. With a prescale of D, the first decrement happens exactly D cycles after the write edge.
- R4: One-shot mode (control bit 17 = 0) counts N down to 0. It fires once, (N+1)·D cycles after the write edge, and then holds at 0 with no further pulses.
- R5: Periodic mode (control bit 17 = 1) reads N − (k mod (N+1)) after k ticks. It fires every (N+1)·D cycles after the write edge.
- R6: An initial count of 0 never produces a pulse, in either mode.
- R7: Control bit 16 = 1 suppresses the pulse. Counting and reloading carry on unchanged.
- R8: Each expiry gives a pulse exactly one cycle wide. The vector output carries control bits 7:0 while the pulse is high.
- R9: Writes to the current-count register have no effect on the count.
- R10: Register select codes are 0 = control entry, 1 = initial count, 2 = current count (read-only) and 3 = divide. Reads are combinational from the selected register or from the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Register selected for a write |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register selected for reading |
| rd_data | output | DATA_W | Combinational read data |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector that goes with the request |

## Verification
Take the clock edge that captures an initial-count write as edge E0. The current count reads N − k after edge E0 + k·D, and the request pulse is visible for the single cycle after edge E0 + (N+1)·D (and after every further multiple in periodic mode). Read data follows the select in the same cycle. The bench counts clock edges from E0 and samples 1 ns after each falling edge. Expected values come from closed-form formulas in that edge count, so every check lands in the cycle where the result is due.

// File: rtl/cdt_pkg.sv
// Shared encodings for the countdown timer: register select codes, control
// entry bit positions and the divide-code to shift mapping.
// Assumes a data width of at least 18 bits so the control bits exist.
package cdt_pkg;

    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_CUR   = 2'd2,
        SEL_DIV   = 2'd3
    } cdt_sel_e;

    localparam int          CDT_SHIFT_W        = 3;
    localparam int          ENTRY_PERIODIC_BIT = 17;
    localparam int          ENTRY_MASK_BIT     = 16;
    localparam logic [31:0] ENTRY_RESET        = 32'h0001_0000;
    localparam logic [3:0]  DIV_KEEP           = 4'hB;

    // Bits 1:0 plus bit 3 form a code; the shift is code+1, wrapping at 8.
    function automatic logic [CDT_SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
        logic [CDT_SHIFT_W-1:0] code;
        code = {cfg[3], cfg[1:0]};
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/cdt_regs.sv
// Register port of the countdown timer: holds the control entry, the
// initial count and the divide configuration, decodes write strobes
// and muxes read data. Assumes single-cycle writes with no handshake.
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    input  logic [DATA_W-1:0] cur_count,
    output logic [DATA_W-1:0] entry_q,
    output logic [DATA_W-1:0] init_q,
    output logic [3:0]        div_q,
    output logic              init_wr,
    output logic              div_wr,
    output logic [DATA_W-1:0] rd_data
);

    logic entry_wr;

    // Decode which register a write strobe targets.
    always_comb begin
        entry_wr = wr_en && (cdt_sel_e'(wr_sel) == SEL_ENTRY);
        init_wr  = wr_en && (cdt_sel_e'(wr_sel) == SEL_INIT);
        div_wr   = wr_en && (cdt_sel_e'(wr_sel) == SEL_DIV);
    end

    // Store software-written registers; the current count is not stored here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= DATA_W'(ENTRY_RESET);
            init_q  <= '0;
            div_q   <= '0;
        end else begin
            if (entry_wr) entry_q <= wr_data;
            if (init_wr)  init_q  <= wr_data;
            if (div_wr)   div_q   <= wr_data[3:0] & DIV_KEEP;
        end
    end

    // Combinational read mux.
    always_comb begin
        case (cdt_sel_e'(rd_sel))
            SEL_ENTRY: rd_data = entry_q;
            SEL_INIT:  rd_data = init_q;
            SEL_CUR:   rd_data = cur_count;
            SEL_DIV:   rd_data = {{(DATA_W-4){1'b0}}, div_q};
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cdt_prescale.sv
// Power-of-two prescaler: emits one tick every 2^shift cycles.
// A restart clears the phase and suppresses the tick in that cycle, so the
// first tick after a restart comes a full period later.
// Assumes shift only changes together with a restart.
module cdt_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    // Terminal phase value for the selected prescale.
    always_comb begin
        limit = {PRE_W{1'b1}} >> (PRE_W - int'(shift));
        tick  = !restart && (pre_cnt == limit);
    end

    // Advance the phase counter, wrapping at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) pre_cnt <= '0;
        else                           pre_cnt <= pre_cnt + 1'b1;
    end

endmodule

// File: rtl/cdt_counter.sv
// Down-counter core: loads on an initial-count write, steps once per tick,
// fires once at zero in one-shot mode or reloads and fires in periodic
// mode, and registers the request pulse and its vector.
// Assumes reload_val equals the stored initial count.
module cdt_counter #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] cur_q,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);

    logic armed;
    logic expire;

    // An expiry is a tick seen at zero with a non-zero period that is still live.
    always_comb begin
        expire = tick && (cur_q == '0) && (reload_val != '0) && (periodic || armed);
    end

    // Count state: load, decrement, periodic reload, one-shot disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cur_q <= load_val;
            armed <= (load_val != '0);
        end else if (tick) begin
            if (cur_q != '0)            cur_q <= cur_q - 1'b1;
            else if (expire && periodic) cur_q <= reload_val;
            if (expire) armed <= 1'b0;
        end
    end

    // Request pulse and vector, gated by the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_pulse <= expire && !masked;
            if (expire && !masked) irq_vector <= vector;
        end
    end

endmodule

// File: rtl/irq_countdown_timer.sv
// Top of the local interrupt countdown timer: ties the register port,
// the prescaler and the down-counter together.
// Assumes DATA_W >= 18 and VEC_W <= 16.
module irq_countdown_timer
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [DATA_W-1:0]      entry_q;
    logic [DATA_W-1:0]      init_q;
    logic [3:0]             div_q;
    logic                   init_wr;
    logic                   div_wr;
    logic [DATA_W-1:0]      cur_q;
    logic                   tick;
    logic [CDT_SHIFT_W-1:0] shift;
    logic                   masked;
    logic                   periodic;

    // Field extraction from the control entry and divide register.
    always_comb begin
        shift    = div_shift(div_q);
        masked   = entry_q[ENTRY_MASK_BIT];
        periodic = entry_q[ENTRY_PERIODIC_BIT];
    end

    cdt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .cur_count (cur_q),
        .entry_q   (entry_q),
        .init_q    (init_q),
        .div_q     (div_q),
        .init_wr   (init_wr),
        .div_wr    (div_wr),
        .rd_data   (rd_data)
    );

    cdt_prescale #(.SHIFT_W(CDT_SHIFT_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (init_wr || div_wr),
        .shift   (shift),
        .tick    (tick)
    );

    cdt_counter #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (init_wr),
        .load_val   (wr_data),
        .reload_val (init_q),
        .periodic   (periodic),
        .masked     (masked),
        .vector     (entry_q[VEC_W-1:0]),
        .cur_q      (cur_q),
        .irq_pulse  (irq_pulse),
        .irq_vector (irq_vector)
    );

endmodule

// File: rtl/irq_countdown_timer_chk.sv
// Property checker for the countdown timer, bound to the top module.
// Observes the pulse, the live count and the control fields across cycles.
module irq_countdown_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_pulse,
    input logic             masked,
    input logic             periodic,
    input logic             init_wr,
    input logic [CNT_W-1:0] init_q,
    input logic [CNT_W-1:0] cur_q
);

    // R8: a request never lasts two cycles.
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R7: a pulse only follows a cycle in which the entry was unmasked.
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(masked));

    // R6: a pulse needs a non-zero period.
    assert_zero_init_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(init_q) != '0));

    // R4: one-shot count parked at zero stays there until reloaded.
    assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && (cur_q == '0) && !init_wr) |=> (cur_q == '0));

    // R5: outside a load the count only steps down by one or wraps to the period.
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q != $past(cur_q)) && !$past(init_wr)) |->
        ((cur_q == $past(cur_q) - CNT_W'(1)) || (($past(cur_q) == '0) && (cur_q == $past(init_q)))));

endmodule

bind irq_countdown_timer irq_countdown_timer_chk #(.CNT_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pulse (irq_pulse),
    .masked    (masked),
    .periodic  (periodic),
    .init_wr   (init_wr),
    .init_q    (init_q),
    .cur_q     (cur_q)
);

// File: tb/test_irq_countdown_timer.sv
`timescale 1ns/1ps
module test_irq_countdown_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;

    irq_countdown_timer i_irq_countdown_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Prescale from a divide code: 2^((code+1) mod 8), code = {b3,b1,b0}.
    function automatic int unsigned div_of(input logic [3:0] cfg);
        int unsigned code;
        code = {cfg[3], cfg[1:0]};
        return 1 << ((code + 1) % 8);
    endfunction

    function automatic logic [31:0] exp_count(input int unsigned n, input int unsigned d,
                                              input int unsigned c, input bit per);
        int unsigned k;
        k = c / d;
        if (per) return n - (k % (n + 1));
        return (k >= n) ? 32'd0 : n - k;
    endfunction

    function automatic bit exp_pulse(input int unsigned n, input int unsigned d,
                                     input int unsigned c, input bit per, input bit msk);
        int unsigned m;
        m = (n + 1) * d;
        return (n != 0) && !msk && (c > 0) && (c % m == 0) && (per || c == m);
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [31:0] val);
        @(negedge clk);
        rd_sel = sel;
        #1 val = rd_data;
    endtask

    // Configure, start, then check count, pulse and vector in every cycle.
    task automatic run_case(input logic [3:0] code, input int unsigned n, input bit per,
                            input bit msk, input logic [7:0] vec, input int unsigned window,
                            input int poke);
        int unsigned d;
        int unsigned e0;
        int unsigned c;
        bit          ep;
        string       tag;
        d = div_of(code);
        write_reg(2'd0, (32'(per) << 17) | (32'(msk) << 16) | 32'(vec));
        write_reg(2'd3, {28'd0, code});
        rd_sel = 2'd2;
        write_reg(2'd1, n);
        e0 = cyc;
        for (int i = 0; i < int'(window); i++) begin
            if (poke >= 0 && i == poke + 1) wr_en = 1'b0;
            #1;
            c  = cyc - e0;
            ep = exp_pulse(n, d, c, per, msk);
            if (i == poke) tag = "R9";
            else if (c <= d) tag = "R3";
            else if (per) tag = "R5";
            else tag = "R4";
            check32(tag, rd_data, exp_count(n, d, c, per));
            tag = msk ? "R7" : (n == 0) ? "R6" : per ? "R5" : "R4";
            check32(tag, {31'd0, irq_pulse}, {31'd0, ep});
            if (ep) check32("R8", {24'd0, irq_vector}, {24'd0, vec});
            if (i == poke) begin
                wr_en = 1'b1; wr_sel = 2'd2; wr_data = $urandom;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, through the R10 register map.
        read_reg(2'd0, v); check32("R1", v, 32'h0001_0000);
        read_reg(2'd1, v); check32("R1", v, 32'd0);
        read_reg(2'd2, v); check32("R1", v, 32'd0);
        read_reg(2'd3, v); check32("R1", v, 32'd0);
        check32("R1", {31'd0, irq_pulse}, 32'd0);

        // R2 divide bits kept; R10 entry readback.
        write_reg(2'd3, 32'hFFFF_FFFF);
        read_reg(2'd3, v); check32("R2", v, 32'h0000_000B);
        write_reg(2'd0, 32'h0002_00AB);
        read_reg(2'd0, v); check32("R10", v, 32'h0002_00AB);
        write_reg(2'd1, 32'h0000_1234);
        read_reg(2'd1, v); check32("R10", v, 32'h0000_1234);

        // Directed corners.
        run_case(4'hB, 1, 1'b1, 1'b0, 8'h21, 12, -1);   // R2 divide by 1, fastest period
        run_case(4'h0, 0, 1'b1, 1'b0, 8'h33, 20, -1);   // R6 periodic zero
        run_case(4'hB, 0, 1'b0, 1'b0, 8'h44, 10, -1);   // R6 one-shot zero
        run_case(4'hB, 3, 1'b1, 1'b1, 8'h55, 20, -1);   // R7 masked, keeps counting
        run_case(4'h1, 6, 1'b0, 1'b0, 8'h66, 40, 9);    // R9 poke current count, R4 hold
        run_case(4'hB, 20, 1'b0, 1'b0, 8'h77, 8, -1);   // R3 restart mid-count
        run_case(4'hB, 2, 1'b1, 1'b0, 8'h88, 20, -1);
        run_case(4'h8, 1, 1'b0, 1'b0, 8'h99, 140, -1);  // R2 code 4 -> divide by 32

        // Random configurations.
        for (int t = 0; t < 14; t++) begin
            logic [3:0]  code;
            int unsigned n;
            int unsigned d;
            bit          per;
            bit          msk;
            code = 4'($urandom % 16);
            n    = 1 + $urandom % 10;
            per  = 1'($urandom % 2);
            msk  = ($urandom % 4) == 0;
            d    = div_of(code);
            run_case(code, n, per, msk, 8'($urandom),
                     per ? 2 * (n + 1) * d + 4 : (n + 2) * d + 4, -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule